// File: doc/BRIEF.md
# Circular trace capture buffer

This block is a trace sink. It stores incoming trace words in an on-chip RAM that it uses as a ring. While capture is on, each valid word goes to the slot at the write pointer and the pointer moves on by one. The pointer wraps at the end of the RAM, and a sticky flag records that the wrap has happened. With the flag clear, the oldest word is at slot 0. With the flag set, the oldest word is at the write pointer.

A trigger input arms a post-trigger counter. Once the programmed number of further words has been captured, the block drops all later words. Software then stops capture with a flush-then-stop handshake. A flush pads the ring with zero words up to the next 4-word frame boundary, and a stop-on-flush option turns capture off when the padding ends. Afterwards software drains the ring through an auto-advancing read pointer and read-data register. Writes through the register port are refused until a key opens the lock register. Reads are always allowed.

Register map (byte offsets on `reg_addr`): 0x00 depth, 0x04 status, 0x08 read pointer, 0x0C write pointer, 0x10 read data, 0x14 write data, 0x18 post-trigger count, 0x1C control, 0x20 flush control, 0x24 flush status, 0x28 lock.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, the depth register (0x00) reads DEPTH. The lock register (0x28) reads 1, meaning locked. Flush status (0x24) reads 1, meaning stopped. The status register (0x04) reads 0. The write pointer (0x0C) reads 0, and control (0x1C) reads 0.
- R2: While locked, a write to any register other than the lock register has no effect. Writing 0xC0DE5EED to 0x28 unlocks the block, and writing any other value locks it again. Reads work in both states.
- R3: With capture off, a write to the write-data register (0x14) stores the word at the write pointer and advances the pointer. The pointer wraps from DEPTH-1 to 0.
- R4: Each read of the read-data register (0x10) with `reg_re` high returns the word at the read pointer and advances the pointer. The pointer wraps from DEPTH-1 to 0.
- R5: While control bit 0 is set, each cycle with `trc_valid` high stores `trc_data` at the write pointer, in arrival order, and advances the pointer.
- R6: Status bit 0 becomes 1 when the write pointer advances past DEPTH-1. A write to the write-pointer register clears it.
- R7: On the first `trc_trigger` while capturing, status bit 1 sets and that cycle's word is still stored. Exactly N more words are then stored, where N is the post-trigger count (0x18). After that, status bit 2 reads 1 and further words are dropped.
- R8: Writing flush control (0x20) with bit 2 set starts a flush. The flush writes zero words, one per cycle, until the write pointer is a multiple of 4. Bit 2 reads 1 until the flush ends.
- R9: If flush-control bit 1 (stop on flush) is set, control bit 0 clears when the flush ends. Flush status bit 0 reads 1 only when capture is off and no flush is pending.
- R10: Clearing control bit 0 while a flush is pending lets the padding finish. Flush status stays 0 until it has finished.
- R11: While capture is on or a flush is pending, writes to the write-pointer, read-pointer and write-data registers have no effect.
- R12: A trace word that arrives in the same cycle as a flush request is stored first. Padding then starts from the pointer position that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (advances the read pointer at 0x10) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | DATA_W | Trace word |
| trc_trigger | input | 1 | Trigger event |

## Verification
The flush request and trace capture can fall in the same cycle. The bench provokes this by driving a flush-control write in the same clock as a valid trace word. It expects the word at the old pointer position, zero padding only in the three slots after it, and a write pointer of 4. A second overlap comes from clearing control while a flush is still padding. In that case flush status must read 0 in the very next cycle and read 1 only once the pointer has reached the frame boundary.

// File: rtl/trs_pkg.sv
package trs_pkg;
  localparam logic [7:0] OFS_DEPTH  = 8'h00;
  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_RPTR   = 8'h08;
  localparam logic [7:0] OFS_WPTR   = 8'h0C;
  localparam logic [7:0] OFS_RDATA  = 8'h10;
  localparam logic [7:0] OFS_WDATA  = 8'h14;
  localparam logic [7:0] OFS_TRIG   = 8'h18;
  localparam logic [7:0] OFS_CTL    = 8'h1C;
  localparam logic [7:0] OFS_FCTL   = 8'h20;
  localparam logic [7:0] OFS_FSTAT  = 8'h24;
  localparam logic [7:0] OFS_LOCK   = 8'h28;

  localparam logic [31:0] UNLOCK_KEY = 32'hC0DE_5EED;

  typedef struct packed {
    logic ctl;
    logic fctl;
    logic trig;
    logic wptr;
    logic rptr;
    logic wdat;
  } wr_sel_t;

  // next ring position for a power-of-two depth
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1) % depth;
  endfunction

  // words already placed in the current frame
  function automatic int unsigned frame_fill(input int unsigned p, input int unsigned frame);
    return p % frame;
  endfunction
endpackage

// File: rtl/trs_ring_ram.sv
module trs_ring_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trs_lock_gate.sv
module trs_lock_gate #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              is_lock_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic              wr_ok
);
  import trs_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)                 locked <= 1'b1;
    else if (we && is_lock_addr) locked <= (wdata != DATA_W'(UNLOCK_KEY));
  end

  assign wr_ok = we && !is_lock_addr && !locked;
endmodule

// File: rtl/trs_capture_ctrl.sv
module trs_capture_ctrl #(
  parameter int DEPTH       = 64,
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 4,
  localparam int PW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  trs_pkg::wr_sel_t  sel,
  input  logic [DATA_W-1:0] wval,
  input  logic              trc_valid,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              trc_trigger,
  output logic              ram_we,
  output logic [PW-1:0]     ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [PW-1:0]     wptr,
  output logic              wrapped,
  output logic              triggered,
  output logic              acq_done,
  output logic              ctl_req,
  output logic              flush_pend,
  output logic              stop_on_flush,
  output logic              fmt_en,
  output logic              capture_on,
  output logic              pad_now,
  output logic [DATA_W-1:0] trig_count
);
  import trs_pkg::*;

  logic [DATA_W-1:0] post_cnt;
  logic accept, trig_hit, flush_done, sw_store;

  always_comb begin
    capture_on = ctl_req | flush_pend;
    acq_done   = triggered && (post_cnt == '0);
    pad_now    = flush_pend && (frame_fill(int'(wptr), FRAME_WORDS) != 0);
    flush_done = flush_pend && !pad_now;
    accept     = ctl_req && !acq_done && !pad_now && trc_valid;
    trig_hit   = ctl_req && !acq_done && !triggered && trc_trigger;
    sw_store   = sel.wdat && !capture_on;
    ram_we     = accept | pad_now | sw_store;
    ram_waddr  = wptr;
    if (pad_now)     ram_wdata = '0;
    else if (accept) ram_wdata = trc_data;
    else             ram_wdata = wval;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr          <= '0;
      wrapped       <= 1'b0;
      triggered     <= 1'b0;
      post_cnt      <= '0;
      ctl_req       <= 1'b0;
      flush_pend    <= 1'b0;
      stop_on_flush <= 1'b0;
      fmt_en        <= 1'b0;
      trig_count    <= '0;
    end else begin
      if (ram_we) begin
        wptr <= PW'(ring_next(int'(wptr), DEPTH));
        if (wptr == PW'(DEPTH - 1)) wrapped <= 1'b1;
      end
      if (sel.wptr && !capture_on) begin
        wptr    <= wval[PW-1:0];
        wrapped <= 1'b0;
      end
      if (trig_hit) begin
        triggered <= 1'b1;
        post_cnt  <= trig_count;
      end else if (accept && triggered) begin
        post_cnt <= post_cnt - 1'b1;
      end
      if (flush_done) begin
        flush_pend <= 1'b0;
        if (stop_on_flush) ctl_req <= 1'b0;
      end
      if (sel.fctl) begin
        fmt_en        <= wval[0];
        stop_on_flush <= wval[1];
        if (wval[2]) flush_pend <= 1'b1;
      end
      if (sel.ctl) begin
        ctl_req <= wval[0];
        if (wval[0] && !ctl_req) triggered <= 1'b0;
      end
      if (sel.trig) trig_count <= wval;
    end
  end
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink #(
  parameter int DEPTH       = 64,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int FRAME_WORDS = 4,
  localparam int PW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              trc_valid,
  input  logic [DATA_W-1:0] trc_data,
  input  logic              trc_trigger
);
  import trs_pkg::*;

  logic              locked, wr_ok, rd_strobe;
  wr_sel_t           sel;
  logic              ram_we;
  logic [PW-1:0]     ram_waddr, wptr_w;
  logic [PW-1:0]     rptr_q;
  logic [DATA_W-1:0] ram_wdata, ram_rdata, trig_count;
  logic              wrapped, triggered, acq_done, ctl_req, flush_pend;
  logic              stop_on_flush, fmt_en, capture_on, pad_now;

  trs_lock_gate #(.DATA_W(DATA_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .we(reg_we),
    .is_lock_addr(reg_addr == ADDR_W'(OFS_LOCK)),
    .wdata(reg_wdata), .locked(locked), .wr_ok(wr_ok)
  );

  always_comb begin
    sel.ctl   = wr_ok && (reg_addr == ADDR_W'(OFS_CTL));
    sel.fctl  = wr_ok && (reg_addr == ADDR_W'(OFS_FCTL));
    sel.trig  = wr_ok && (reg_addr == ADDR_W'(OFS_TRIG));
    sel.wptr  = wr_ok && (reg_addr == ADDR_W'(OFS_WPTR));
    sel.rptr  = wr_ok && (reg_addr == ADDR_W'(OFS_RPTR));
    sel.wdat  = wr_ok && (reg_addr == ADDR_W'(OFS_WDATA));
    rd_strobe = reg_re && (reg_addr == ADDR_W'(OFS_RDATA));
  end

  trs_capture_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FRAME_WORDS(FRAME_WORDS)) u_cap (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wval(reg_wdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_trigger(trc_trigger),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .wptr(wptr_w), .wrapped(wrapped), .triggered(triggered), .acq_done(acq_done),
    .ctl_req(ctl_req), .flush_pend(flush_pend), .stop_on_flush(stop_on_flush),
    .fmt_en(fmt_en), .capture_on(capture_on), .pad_now(pad_now),
    .trig_count(trig_count)
  );

  trs_ring_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(rptr_q), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                       rptr_q <= '0;
    else if (sel.rptr && !capture_on) rptr_q <= reg_wdata[PW-1:0];
    else if (rd_strobe)               rptr_q <= PW'(ring_next(int'(rptr_q), DEPTH));
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFS_DEPTH):  reg_rdata = DATA_W'(DEPTH);
      ADDR_W'(OFS_STATUS): reg_rdata = DATA_W'({acq_done, triggered, wrapped});
      ADDR_W'(OFS_RPTR):   reg_rdata = DATA_W'(rptr_q);
      ADDR_W'(OFS_WPTR):   reg_rdata = DATA_W'(wptr_w);
      ADDR_W'(OFS_RDATA):  reg_rdata = ram_rdata;
      ADDR_W'(OFS_TRIG):   reg_rdata = trig_count;
      ADDR_W'(OFS_CTL):    reg_rdata = DATA_W'(ctl_req);
      ADDR_W'(OFS_FCTL):   reg_rdata = DATA_W'({flush_pend, stop_on_flush, fmt_en});
      ADDR_W'(OFS_FSTAT):  reg_rdata = DATA_W'(!capture_on);
      ADDR_W'(OFS_LOCK):   reg_rdata = DATA_W'(locked);
      default:             reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int DEPTH       = 64,
  parameter int ADDR_W      = 8,
  parameter int FRAME_WORDS = 4,
  localparam int PW         = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              locked,
  input logic              ctl_req,
  input logic              ram_we,
  input logic [PW-1:0]     wptr,
  input logic [PW-1:0]     rptr,
  input logic              flush_pend,
  input logic              acq_done,
  input logic              capture_on,
  input logic              pad_now
);
  import trs_pkg::*;

  // R2: a locked control write leaves capture enable untouched
  a_r2_locked_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    locked && reg_we && reg_addr == ADDR_W'(OFS_CTL) && !flush_pend |=> $stable(ctl_req));

  // R5: every RAM write moves the write pointer on by exactly one
  a_r5_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> wptr == PW'($past(wptr) + 1'b1));

  // R4: a read-data access advances the read pointer
  a_r4_rptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re && reg_addr == ADDR_W'(OFS_RDATA) |=> rptr == PW'($past(rptr) + 1'b1));

  // R7: nothing is captured once post-trigger count is exhausted
  a_r7_halted: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done && ctl_req && !pad_now |-> !ram_we);

  // R8: a flush ends only on a frame boundary
  a_r8_flush_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_pend) |-> ($past(wptr) & PW'(FRAME_WORDS - 1)) == '0);

  // R11: software cannot move the write pointer while capture is on
  a_r11_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    capture_on && !ram_we |=> $stable(wptr));
endmodule

bind trace_ring_sink trs_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
  .locked(locked), .ctl_req(ctl_req), .ram_we(ram_we), .wptr(wptr_w), .rptr(rptr_q),
  .flush_pend(flush_pend), .acq_done(acq_done), .capture_on(capture_on), .pad_now(pad_now)
);

// File: tb/trace_ring_sink_tb.sv
`timescale 1ns/1ps
module trace_ring_sink_tb;
  localparam int D = 16;
  localparam logic [7:0] A_DEPTH = 8'h00, A_STAT = 8'h04, A_RPTR = 8'h08, A_WPTR = 8'h0C,
    A_RDAT = 8'h10, A_WDAT = 8'h14, A_TRIG = 8'h18, A_CTL = 8'h1C, A_FCTL = 8'h20,
    A_FSTAT = 8'h24, A_LOCK = 8'h28;
  localparam logic [31:0] KEY = 32'hC0DE5EED;

  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 0;
  logic reg_we = 0, reg_re = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic trc_valid = 0, trc_trigger = 0;
  logic [31:0] trc_data = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  trace_ring_sink #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trc_valid(trc_valid),
    .trc_data(trc_data), .trc_trigger(trc_trigger)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  // R3 / R4 / R6 register-path vectors
  localparam vec_t VEC [19] = '{
    '{1'b0, 8'h0C, 32'h0,  4'd3},  // wptr = 0
    '{1'b0, 8'h14, 32'h11, 4'd3},
    '{1'b0, 8'h14, 32'h22, 4'd3},
    '{1'b0, 8'h14, 32'h33, 4'd3},
    '{1'b1, 8'h0C, 32'd3,  4'd3},  // R3 pointer advanced
    '{1'b0, 8'h08, 32'h0,  4'd4},
    '{1'b1, 8'h10, 32'h11, 4'd4},  // R4 dump order
    '{1'b1, 8'h10, 32'h22, 4'd4},
    '{1'b1, 8'h10, 32'h33, 4'd4},
    '{1'b1, 8'h08, 32'd3,  4'd4},
    '{1'b0, 8'h0C, 32'd15, 4'd3},
    '{1'b0, 8'h14, 32'hAA, 4'd3},
    '{1'b1, 8'h0C, 32'd0,  4'd3},  // R3 wrap to 0
    '{1'b1, 8'h04, 32'd1,  4'd6},  // R6 wrap flag
    '{1'b0, 8'h0C, 32'd0,  4'd6},
    '{1'b1, 8'h04, 32'd0,  4'd6},  // R6 cleared
    '{1'b0, 8'h08, 32'd15, 4'd4},
    '{1'b1, 8'h10, 32'hAA, 4'd4},
    '{1'b1, 8'h08, 32'd0,  4'd4}   // R4 wrap
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input int req);
    @(negedge clk);
    reg_addr = a; reg_re = 1;
    #2 check(req, reg_rdata, exp);
    @(posedge clk); #1 reg_re = 0;
  endtask

  task automatic push(input logic [31:0] d, input logic t);
    @(negedge clk);
    trc_valid = 1; trc_data = d; trc_trigger = t;
    @(posedge clk); #1 trc_valid = 0; trc_trigger = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    // R1 reset values
    rd(A_DEPTH, D, 1); rd(A_LOCK, 1, 1); rd(A_FSTAT, 1, 1);
    rd(A_STAT, 0, 1); rd(A_WPTR, 0, 1); rd(A_CTL, 0, 1);
    // R2 writes refused while locked
    wr(A_CTL, 1); rd(A_CTL, 0, 2);
    wr(A_WPTR, 5); rd(A_WPTR, 0, 2);
    wr(A_LOCK, KEY); rd(A_LOCK, 0, 2);

    for (int i = 0; i < 19; i++) begin
      if (VEC[i].rd) rd(VEC[i].a, VEC[i].d, int'(VEC[i].req));
      else           wr(VEC[i].a, VEC[i].d);
    end

    // R5 / R7 capture with trigger and post count 2
    wr(A_WPTR, 0); wr(A_TRIG, 2); wr(A_CTL, 1);
    push(32'hA0, 0); push(32'hA1, 0); push(32'hA2, 1);
    push(32'hA3, 0); push(32'hA4, 0); push(32'hA5, 0); push(32'hA6, 0);
    rd(A_WPTR, 5, 7); rd(A_STAT, 6, 7);
    // R11 pointer and data writes ignored while capturing
    wr(A_WPTR, 9); rd(A_WPTR, 5, 11);
    wr(A_WDAT, 32'hDEAD); rd(A_WPTR, 5, 11);
    wr(A_RPTR, 7); rd(A_RPTR, 0, 11);
    // R8 / R9 flush with stop
    wr(A_FCTL, 6); rd(A_FCTL, 6, 8);
    idle(8);
    rd(A_FCTL, 2, 8); rd(A_WPTR, 8, 8); rd(A_CTL, 0, 9); rd(A_FSTAT, 1, 9);
    wr(A_RPTR, 0);
    rd(A_RDAT, 32'hA0, 5); rd(A_RDAT, 32'hA1, 5); rd(A_RDAT, 32'hA2, 7);
    rd(A_RDAT, 32'hA3, 7); rd(A_RDAT, 32'hA4, 7);
    rd(A_RDAT, 0, 8); rd(A_RDAT, 0, 8); rd(A_RDAT, 0, 8);

    // R10 disable while flush pending
    wr(A_WPTR, 0); wr(A_CTL, 1); push(32'hB0, 0);
    wr(A_FCTL, 4); wr(A_CTL, 0);
    rd(A_FSTAT, 0, 10);
    idle(6);
    rd(A_FSTAT, 1, 10); rd(A_WPTR, 4, 10); rd(A_CTL, 0, 10);

    // R12 trace word and flush request in one cycle
    wr(A_WPTR, 0); wr(A_CTL, 1);
    @(negedge clk);
    trc_valid = 1; trc_data = 32'hC0; reg_addr = A_FCTL; reg_we = 1; reg_wdata = 4;
    @(posedge clk); #1 trc_valid = 0; reg_we = 0;
    idle(6);
    rd(A_CTL, 1, 12); wr(A_CTL, 0); rd(A_WPTR, 4, 12);
    wr(A_RPTR, 0);
    rd(A_RDAT, 32'hC0, 12); rd(A_RDAT, 0, 12); rd(A_RDAT, 0, 12); rd(A_RDAT, 0, 12);

    // R2 relock
    wr(A_LOCK, 0); wr(A_TRIG, 7); wr(A_CTL, 1);
    rd(A_CTL, 0, 2); rd(A_LOCK, 1, 2); rd(A_TRIG, 2, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule